// File: doc/BRIEF.md
# Serial Flash Status Register Engine

This block is the command front end of a serial-flash slave model. It watches a SPI mode 0 bus (clock idle low, data sampled on the rising clock edge, most significant bit first), collects the command bytes of each transaction and keeps the device's 8-bit status word. Three status bits have fixed meanings. Bit 0 is the busy flag. Bit 1 is the write-enable latch. Bit 6 marks an auto-address-increment word-program sequence. The other bits are plain storage that a status write can set.

Commands take effect when the chip select returns high. The engine answers a status read with the live status byte on MISO. It answers an array read with a constant fill byte, because the array itself is not modelled. While an auto-increment sequence is open, it rejects every opcode outside a small allowed set, and it raises an error flag when it rejects a command. The bus pins are oversampled by a system clock through a configurable synchronizer. The SPI clock must therefore be several times slower than that system clock.

Top module: `spi_sr_engine`

## Requirements
- R1: After reset the status word equals the parameter INIT_STATUS (default 8'h00), `err_flag` is 0 and `miso` is 0.
- R2: Opcode 8'h05 returns the status word as it stood when the command started. The bytes are shifted out MSB first, changing after falling SCK edges, and the same byte repeats in every byte position after the opcode for as long as `cs_n` stays low.
- R3: Opcodes 8'h06 and 8'h50 each set status bit 1 (write-enable latch) when accepted.
- R4: Opcode 8'h01 with at least two complete bytes, sent while bit 1 is set, loads the second byte into the status word with bit 0 forced to 0 and bit 1 then cleared. When bit 1 is 0 the status word is left unchanged.
- R5: Every accepted command other than 8'h06 and 8'h50 leaves bit 1 cleared, including a status read.
- R6: While bit 6 is set, only opcodes 8'hAD, 8'h04 and 8'h05 are accepted. Any other opcode is rejected, leaves the status word unchanged and sets `err_flag`.
- R7: Opcode 8'hAD while bit 6 is clear sets bit 6 when the transaction holds at least 6 complete bytes (opcode, 24-bit address, two data bytes). A shorter one is rejected: the status word is unchanged and `err_flag` is set. While bit 6 is set, 8'hAD continues the sequence without error.
- R8: Opcode 8'h04 clears bit 6.
- R9: A transaction that ends before its first byte is complete is discarded, and the status word is unchanged.
- R10: Opcode 8'h03 returns 8'h00 during its three address bytes and then ARRAY_FILL (default 8'hFF) in every later byte.
- R11: `err_flag` is set when a rejected command ends and clears on the next falling edge of `cs_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus pins |
| rst_n | input | 1 | Active-low asynchronous reset; loads INIT_STATUS |
| sck | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | Active-low chip select; its rising edge commits a command |
| mosi | input | 1 | Serial command and data input, MSB first |
| miso | output | 1 | Serial response output; 0 while deselected |
| err_flag | output | 1 | Set when a command is rejected, cleared at the next selection |

## Verification
Directed sequences step through the latch rules. These are a status write with and without the enable latch, each of the two enable opcodes followed by a read, and a read that clears the latch. A truncated opcode, a short and a full auto-increment start, and opcodes blocked inside that sequence separate acceptance from rejection. Random streams of mixed opcodes, with random lengths and random status-write data, then reach state pairs the directed list misses. Examples are random writes that open the auto-increment mode, and reads taken in and out of that mode. A bench model predicts the status and error flag after every transaction.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;
   localparam logic [7:0] OP_WRSR = 8'h01;
   localparam logic [7:0] OP_READ = 8'h03;
   localparam logic [7:0] OP_WRDI = 8'h04;
   localparam logic [7:0] OP_RDSR = 8'h05;
   localparam logic [7:0] OP_WREN = 8'h06;
   localparam logic [7:0] OP_EWSR = 8'h50;
   localparam logic [7:0] OP_AAIW = 8'hAD;

   localparam int SR_BUSY = 0;
   localparam int SR_WEL  = 1;
   localparam int SR_AINC = 6;

   localparam int AAI_MIN_BYTES = 6;

   function automatic logic ainc_allowed(input logic [7:0] op);
      return (op == OP_AAIW) || (op == OP_WRDI) || (op == OP_RDSR);
   endfunction

   function automatic logic keeps_wel(input logic [7:0] op);
      return (op == OP_WREN) || (op == OP_EWSR);
   endfunction
endpackage

// File: rtl/spi_sr_sync.sv
module spi_sr_sync #(
   parameter int WIDTH = 3,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   generate
      if (STAGES == 0) begin : g_direct
         assign d_out = d_in;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
            end else begin
               stage_q[0] <= d_in;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign d_out = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spi_sr_byte_rx.sv
module spi_sr_byte_rx #(
   parameter int BYTE_CNT_W = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  bit_stb,
   input  logic                  din,
   output logic [7:0]            opcode,
   output logic [7:0]            arg,
   output logic [BYTE_CNT_W-1:0] nbytes,
   output logic [2:0]            bitcnt
);
   localparam logic [BYTE_CNT_W-1:0] CNT_MAX = '1;

   logic [6:0] shreg_q;
   logic [7:0] full_byte;

   assign full_byte = {shreg_q, din};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         bitcnt  <= '0;
         nbytes  <= '0;
         opcode  <= '0;
         arg     <= '0;
      end else if (start) begin
         bitcnt <= '0;
         nbytes <= '0;
      end else if (bit_stb) begin
         shreg_q <= full_byte[6:0];
         bitcnt  <= bitcnt + 3'd1;
         if (bitcnt == 3'd7) begin
            if (nbytes == '0) opcode <= full_byte;
            if (nbytes == BYTE_CNT_W'(1)) arg <= full_byte;
            if (nbytes != CNT_MAX) nbytes <= nbytes + BYTE_CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/spi_sr_resp_tx.sv
module spi_sr_resp_tx
   import spi_sr_pkg::*;
#(
   parameter int BYTE_CNT_W = 3,
   parameter logic [7:0] ARRAY_FILL = 8'hFF
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  shift_stb,
   input  logic [2:0]            bitcnt,
   input  logic [BYTE_CNT_W-1:0] nbytes,
   input  logic [7:0]            opcode,
   input  logic [7:0]            status,
   output logic                  dout
);
   localparam logic [BYTE_CNT_W-1:0] READ_HDR = BYTE_CNT_W'(4);

   logic [7:0] out_q;
   logic [7:0] resp;
   logic       boundary;

   assign boundary = (bitcnt == 3'd0) && (nbytes != '0);

   always_comb begin
      resp = 8'h00;
      if (opcode == OP_RDSR) resp = status;
      else if (opcode == OP_READ && nbytes >= READ_HDR) resp = ARRAY_FILL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= '0;
      else if (start) out_q <= '0;
      else if (shift_stb) out_q <= boundary ? resp : {out_q[6:0], 1'b0};
   end

   assign dout = out_q[7];
endmodule

// File: rtl/spi_sr_core.sv
module spi_sr_core
   import spi_sr_pkg::*;
#(
   parameter int BYTE_CNT_W = 3,
   parameter logic [7:0] INIT_STATUS = 8'h00
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  commit,
   input  logic                  start,
   input  logic [7:0]            opcode,
   input  logic [7:0]            arg,
   input  logic [BYTE_CNT_W-1:0] nbytes,
   output logic [7:0]            status,
   output logic                  err
);
   localparam logic [BYTE_CNT_W-1:0] AAI_MIN = BYTE_CNT_W'(AAI_MIN_BYTES);
   localparam logic [BYTE_CNT_W-1:0] WRSR_MIN = BYTE_CNT_W'(2);

   logic [7:0] nxt;
   logic       reject;
   logic       take;

   assign take = commit && (nbytes != '0);

   always_comb begin
      nxt    = status;
      reject = 1'b0;
      if (take) begin
         if (status[SR_AINC] && !ainc_allowed(opcode)) begin
            reject = 1'b1;
         end else begin
            case (opcode)
               OP_WREN, OP_EWSR: nxt[SR_WEL] = 1'b1;
               OP_WRSR: begin
                  if (status[SR_WEL] && nbytes >= WRSR_MIN) begin
                     nxt = arg;
                     nxt[SR_BUSY] = 1'b0;
                  end
               end
               OP_AAIW: begin
                  if (!status[SR_AINC]) begin
                     if (nbytes >= AAI_MIN) nxt[SR_AINC] = 1'b1;
                     else reject = 1'b1;
                  end
               end
               OP_WRDI: nxt[SR_AINC] = 1'b0;
               default: ;
            endcase
            if (reject) nxt = status;
            else if (!keeps_wel(opcode)) nxt[SR_WEL] = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= INIT_STATUS;
         err    <= 1'b0;
      end else begin
         status <= nxt;
         if (reject) err <= 1'b1;
         else if (start) err <= 1'b0;
      end
   end
endmodule

// File: rtl/spi_sr_engine.sv
module spi_sr_engine #(
   parameter logic [7:0] INIT_STATUS = 8'h00,
   parameter logic [7:0] ARRAY_FILL = 8'hFF,
   parameter int SYNC_STAGES = 2,
   parameter int BYTE_CNT_W = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic mosi,
   output logic miso,
   output logic err_flag
);
   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..3");
      end
      if (BYTE_CNT_W < 3) begin : g_bad_cnt
         $error("BYTE_CNT_W must count to at least 6 bytes");
      end
   endgenerate

   logic [2:0]            pins_s;
   logic                  sck_s, cs_s, mosi_s;
   logic                  sck_d, cs_d;
   logic                  sck_rise, sck_fall, cs_rise, cs_fall;
   logic [7:0]            opcode, arg, status_q;
   logic [BYTE_CNT_W-1:0] nbytes;
   logic [2:0]            bitcnt;
   logic                  tx_bit;

   spi_sr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in({sck, cs_n, mosi}), .d_out(pins_s)
   );
   assign {sck_s, cs_s, mosi_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         cs_d  <= 1'b1;
      end else begin
         sck_d <= sck_s;
         cs_d  <= cs_s;
      end
   end

   assign sck_rise = sck_s && !sck_d && !cs_s;
   assign sck_fall = !sck_s && sck_d && !cs_s;
   assign cs_rise  = cs_s && !cs_d;
   assign cs_fall  = !cs_s && cs_d;

   spi_sr_byte_rx #(.BYTE_CNT_W(BYTE_CNT_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .start(cs_fall), .bit_stb(sck_rise), .din(mosi_s),
      .opcode(opcode), .arg(arg), .nbytes(nbytes), .bitcnt(bitcnt)
   );

   spi_sr_core #(.BYTE_CNT_W(BYTE_CNT_W), .INIT_STATUS(INIT_STATUS)) u_core (
      .clk(clk), .rst_n(rst_n), .commit(cs_rise), .start(cs_fall), .opcode(opcode),
      .arg(arg), .nbytes(nbytes), .status(status_q), .err(err_flag)
   );

   spi_sr_resp_tx #(.BYTE_CNT_W(BYTE_CNT_W), .ARRAY_FILL(ARRAY_FILL)) u_tx (
      .clk(clk), .rst_n(rst_n), .start(cs_fall), .shift_stb(sck_fall), .bitcnt(bitcnt),
      .nbytes(nbytes), .opcode(opcode), .status(status_q), .dout(tx_bit)
   );

   assign miso = tx_bit && !cs_s;
endmodule

// File: rtl/spi_sr_engine_checker.sv
module spi_sr_engine_checker
   import spi_sr_pkg::*;
#(
   parameter int BYTE_CNT_W = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  commit,
   input logic                  start,
   input logic [7:0]            opcode,
   input logic [7:0]            arg,
   input logic [BYTE_CNT_W-1:0] nbytes,
   input logic [7:0]            status,
   input logic                  err
);
   logic took;
   assign took = commit && (nbytes != '0);

   p_hold_unless_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !took |=> $stable(status));

   p_blocked_in_ainc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (took && status[SR_AINC] && !ainc_allowed(opcode)) |=> ($stable(status) && err));

   p_enable_sets_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (took && !status[SR_AINC] && keeps_wel(opcode)) |=> status[SR_WEL]);

   p_other_clears_wel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (took && !keeps_wel(opcode)) |=> (!status[SR_WEL] || $stable(status)));

   p_wrsr_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (took && opcode == OP_WRSR && nbytes >= BYTE_CNT_W'(2) && status[SR_WEL] && !status[SR_AINC])
      |=> (!status[SR_BUSY] && status[7:2] == $past(arg[7:2])));

   p_wrdi_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (took && opcode == OP_WRDI) |=> !status[SR_AINC]);

   p_err_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !err);
endmodule

bind spi_sr_engine spi_sr_engine_checker #(.BYTE_CNT_W(BYTE_CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .commit(cs_rise), .start(cs_fall), .opcode(opcode),
   .arg(arg), .nbytes(nbytes), .status(status_q), .err(err_flag)
);

// File: tb/spi_sr_engine_test.sv
module spi_sr_engine_test;
   localparam int HALF = 6;
   localparam logic [7:0] INIT = 8'h80;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic miso, err_flag;

   int n_tests = 0;
   int n_fail = 0;
   bit done = 0;

   logic [7:0] tx [8];
   logic [7:0] rx [8];
   logic [7:0] exp_st = INIT;
   logic       exp_err = 1'b0;

   always #2 clk = ~clk;

   spi_sr_engine #(.INIT_STATUS(INIT)) uut (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
      .miso(miso), .err_flag(err_flag)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", tag, act, exp);
      end
   endtask

   function automatic void model(input logic [7:0] op, input logic [7:0] arg, input int n);
      logic rej;
      exp_err = 1'b0;
      if (n == 0) return;
      if (exp_st[6] && !(op == 8'hAD || op == 8'h04 || op == 8'h05)) begin
         exp_err = 1'b1;
         return;
      end
      rej = 1'b0;
      case (op)
         8'h06, 8'h50: exp_st[1] = 1'b1;
         8'h01: if (exp_st[1] && n >= 2) exp_st = {arg[7:1], 1'b0};
         8'hAD: if (!exp_st[6]) begin
            if (n >= 6) exp_st[6] = 1'b1;
            else rej = 1'b1;
         end
         8'h04: exp_st[6] = 1'b0;
         default: ;
      endcase
      if (rej) exp_err = 1'b1;
      else if (op != 8'h06 && op != 8'h50) exp_st[1] = 1'b0;
   endfunction

   task automatic xfer(input int nfull, input int extra);
      cs_n = 1'b0;
      repeat (8) @(negedge clk);
      for (int i = 0; i < nfull; i++) begin
         rx[i] = 8'h00;
         for (int b = 7; b >= 0; b--) begin
            mosi = tx[i][b];
            repeat (HALF) @(negedge clk);
            rx[i][b] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
         end
      end
      for (int b = 0; b < extra; b++) begin
         mosi = tx[nfull][7-b];
         repeat (HALF) @(negedge clk);
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
      end
      mosi = 1'b0;
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   task automatic run_cmd(input logic [7:0] op, input logic [7:0] arg, input int nfull,
                          input int extra, input string tag);
      logic [7:0] pre;
      tx[0] = op;
      tx[1] = arg;
      for (int i = 2; i < 8; i++) tx[i] = 8'($urandom);
      pre = exp_st;
      xfer(nfull, extra);
      model(op, arg, nfull);
      check({tag, " err_flag"}, {7'd0, err_flag}, {7'd0, exp_err});
      if (op == 8'h05)
         for (int i = 1; i < nfull; i++) check({tag, " status byte"}, rx[i], pre);
      if (op == 8'h03 && !pre[6])
         for (int i = 1; i < nfull; i++) check({tag, " read byte"}, rx[i], (i >= 4) ? 8'hFF : 8'h00);
   endtask

   task automatic read_status(input string tag);
      run_cmd(8'h05, 8'h00, 3, 0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] ops [8];
      ops = '{8'h05, 8'h06, 8'h50, 8'h01, 8'h04, 8'hAD, 8'h03, 8'h00};
      void'($urandom(32'd1234));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R1: reset state at the ports, then the initial status value
      check("R1 err_flag", {7'd0, err_flag}, 8'h00);
      check("R1 miso", {7'd0, miso}, 8'h00);
      read_status("R1");
      check("R1 literal", rx[1], INIT);
      // R2: status repeated over several bytes
      run_cmd(8'h05, 8'h00, 5, 0, "R2");
      // R4: status write without enable is ignored
      run_cmd(8'h01, 8'h3C, 2, 0, "R4");
      read_status("R4");
      check("R4 ignored", rx[1], INIT);
      // R3: write enable sets latch; R5: the read clears it
      run_cmd(8'h06, 8'h00, 1, 0, "R3");
      read_status("R3");
      check("R3 wel set", rx[1], INIT | 8'h02);
      read_status("R5");
      check("R5 wel cleared", rx[1], INIT);
      // R4: enable-write-status then write, busy bit forced low
      run_cmd(8'h50, 8'h00, 1, 0, "R3");
      run_cmd(8'h01, 8'h3F, 2, 0, "R4");
      read_status("R4");
      check("R4 loaded", rx[1], 8'h3C);
      // R9: truncated opcode discarded, latch kept
      run_cmd(8'h06, 8'h00, 1, 0, "R9");
      run_cmd(8'h04, 8'h00, 0, 4, "R9");
      read_status("R9");
      check("R9 unchanged", rx[1], 8'h3E);
      // R10: array read returns fill after address
      run_cmd(8'h03, 8'h00, 7, 0, "R10");
      // R7: short auto-increment start rejected; R11: flag cleared next select
      run_cmd(8'hAD, 8'h00, 4, 0, "R7");
      check("R7 err set", {7'd0, err_flag}, 8'h01);
      read_status("R11");
      check("R11 err cleared", {7'd0, err_flag}, 8'h00);
      check("R7 no ainc", rx[1] & 8'h40, 8'h00);
      // R7: full start enters mode
      run_cmd(8'hAD, 8'h00, 6, 0, "R7");
      read_status("R7");
      check("R7 ainc set", rx[1], 8'h7C);
      // R6: blocked opcodes inside the sequence
      run_cmd(8'h06, 8'h00, 1, 0, "R6");
      check("R6 err set", {7'd0, err_flag}, 8'h01);
      run_cmd(8'h03, 8'h00, 4, 0, "R6");
      read_status("R6");
      check("R6 unchanged", rx[1], 8'h7C);
      run_cmd(8'hAD, 8'h00, 3, 0, "R7");
      check("R7 continue ok", {7'd0, err_flag}, 8'h00);
      // R8: write disable leaves the sequence
      run_cmd(8'h04, 8'h00, 1, 0, "R8");
      read_status("R8");
      check("R8 ainc cleared", rx[1], 8'h3C);
      // random mix, checked against the model (R2..R11)
      for (int it = 0; it < 100; it++) begin
         int k, nf, ex;
         logic [7:0] op;
         k = int'($urandom % 8);
         op = (k == 7) ? 8'($urandom) : ops[k];
         nf = int'($urandom % 8);
         ex = (nf == 0) ? 1 + int'($urandom % 7) : 0;
         run_cmd(op, 8'($urandom), nf, ex, "R6 random");
         if ($urandom % 2 == 0) read_status("R2 random");
      end
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule